// File: doc/BRIEF.md
# Instruction Step Sequencer with Halt and Sleep

This block paces a small CPU core through each instruction. Every instruction opens with a fetch phase and continues with execute steps. Its total length is 5, 7 or 12 clocks, selected by a two-bit length class from the decoder. The block outputs the step number within the current phase, a flag that tells fetch from execute, and a strobe in the final step. The rest of the core uses these to time register transfers and memory accesses.

The block also implements two stop modes. A halt or sleep command that is present in the final step of an instruction makes the block raise a one-clock request to push the return address. It then stops stepping. In sleep mode it also raises a clock-stop output that the oscillator logic uses to gate the system clock. In halt mode the clock keeps running. Only an enabled interrupt request ends either mode. The clock-stop output drops in the same cycle as the request, and stepping restarts at fetch step 0 on the next clock.

Top module: `instr_step_seq`

## Requirements
- R1: Instruction length in clocks is set by `len_class`: 2'b00 gives 5, 2'b01 gives 7, and 2'b10 or 2'b11 gives 12.
- R2: The first 3 clocks of every instruction are fetch, with `exec_phase` at 0. The remaining clocks are execute, with `exec_phase` at 1.
- R3: `state_num` counts 0,1,2 during fetch and restarts at 0 for the first execute clock, rising by one each clock after that.
- R4: `len_class` is sampled only in fetch step 0. Later changes within the same instruction do not alter its length.
- R5: `instr_end` is high for exactly one clock, the last clock of each instruction, and at no other time.
- R6: When `halt_cmd` or `sleep_cmd` is high in the last clock of an instruction, `push_req` is high for exactly the next clock. The block then stays stopped, with `state_num` 0, `exec_phase` 0 and `instr_end` 0.
- R7: While stopped by halt, `clk_stop` stays 0.
- R8: While stopped by sleep, `clk_stop` is 1. If both commands are high together, sleep takes effect.
- R9: A stop ends only on a clock where `irq_req` and `irq_en` are both 1. With `irq_en` at 0 the block remains stopped for as long as that lasts.
- R10: On the clock where an enabled interrupt is seen in the stopped state, `clk_stop` is already 0. The next clock is fetch step 0 of a full instruction.
- R11: While `rst_n` is low at a clock edge, every output returns to 0. After reset the first clock is fetch step 0.
- R12: Halt or sleep commands outside the last clock of an instruction have no effect. Interrupt requests have no effect while running or during the push clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| len_class | input | 2 | Instruction length class from decode |
| halt_cmd | input | 1 | Current instruction is a halt |
| sleep_cmd | input | 1 | Current instruction is a sleep |
| irq_req | input | 1 | Interrupt request pending |
| irq_en | input | 1 | Interrupts enabled |
| state_num | output | 4 | Step number within the current phase |
| exec_phase | output | 1 | 0 in fetch, 1 in execute |
| instr_end | output | 1 | Last clock of the instruction |
| push_req | output | 1 | Request to push the return address |
| clk_stop | output | 1 | Request to stop the system clock |

## Verification
The bench changes `len_class` in the middle of instructions. A design that decoded length from the live class rather than the sampled one would end instructions early or late. It keeps a pending interrupt with interrupts disabled across a long stop, which catches a design that wakes on any request. It checks `clk_stop` in the same cycle as an enabled wake, to catch a registered release one clock late. It also drives halt and sleep in steps other than the last, and both at once. A wrong design would either stop mid-instruction or fail to gate the clock in that case.

// File: rtl/seq_pkg.sv
// Shared types for the instruction step sequencer.
// Assumes: length class encoding 2'b11 behaves as the long class.
package seq_pkg;
    typedef enum logic [1:0] {
        LC_SHORT = 2'b00,
        LC_MID   = 2'b01,
        LC_LONG  = 2'b10,
        LC_ALT   = 2'b11
    } len_class_e;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_PUSH = 2'b01,
        MODE_STOP = 2'b10
    } seq_mode_e;
endpackage

// File: rtl/seq_len_decode.sv
// Maps the decoder's length class to a clock count.
// Assumes: all lengths fit in CNT_W bits and exceed the fetch length.
module seq_len_decode #(
    parameter int CNT_W     = 4,
    parameter int LEN_SHORT = 5,
    parameter int LEN_MID   = 7,
    parameter int LEN_LONG  = 12
) (
    input  logic [1:0]       len_class,
    output logic [CNT_W-1:0] len_clocks
);
    import seq_pkg::*;

    // Select the clock count for the class.
    always_comb begin
        unique case (len_class_e'(len_class))
            LC_SHORT: len_clocks = CNT_W'(LEN_SHORT);
            LC_MID:   len_clocks = CNT_W'(LEN_MID);
            default:  len_clocks = CNT_W'(LEN_LONG);
        endcase
    end
endmodule

// File: rtl/seq_step_counter.sv
// Counts clocks within one instruction and derives phase and step number.
// Assumes: run_en is low while stopped; the length is latched in step 0.
module seq_step_counter #(
    parameter int CNT_W     = 4,
    parameter int FETCH_LEN = 3,
    parameter int MAX_LEN   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] new_len,
    output logic             last,
    output logic [CNT_W-1:0] state_num,
    output logic             exec_phase
);
    localparam logic [CNT_W-1:0] FETCH_C = CNT_W'(FETCH_LEN);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cur_len;

    // Use the live class only in step 0, the latched one afterwards.
    assign cur_len = (cnt_q == '0) ? new_len : len_q;
    assign last    = run_en && (cnt_q == cur_len - ONE_C);

    // Advance the clock counter, wrapping at the instruction end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_en) begin
            cnt_q <= last ? '0 : cnt_q + ONE_C;
        end
    end

    // Latch the instruction length in fetch step 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= CNT_W'(MAX_LEN);
        end else if (run_en && cnt_q == '0) begin
            len_q <= new_len;
        end
    end

    // Split the count into phase flag and per-phase step number.
    always_comb begin
        exec_phase = run_en && (cnt_q >= FETCH_C);
        state_num  = exec_phase ? cnt_q - FETCH_C : cnt_q;
    end

    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_LEN));

    assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !last) |=> (cnt_q == $past(cnt_q) + ONE_C));

    assert_end_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt_q == '0));

    assert_len_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> $stable(len_q));
endmodule

// File: rtl/seq_stop_ctrl.sv
// Run / push / stop mode control for halt and sleep.
// Assumes: commands are only honoured in the last clock of an instruction;
// irq_req and irq_en come from the interrupt logic of the same clock domain.
module seq_stop_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic last,
    input  logic halt_cmd,
    input  logic sleep_cmd,
    input  logic irq_req,
    input  logic irq_en,
    output logic run_en,
    output logic push_req,
    output logic clk_stop
);
    import seq_pkg::*;

    seq_mode_e mode_q;
    logic      sleep_q;
    logic      wake;

    assign wake     = irq_req && irq_en;
    assign run_en   = (mode_q == MODE_RUN);
    assign push_req = (mode_q == MODE_PUSH);
    // Release the clock gate as soon as an enabled interrupt shows up.
    assign clk_stop = (mode_q == MODE_STOP) && sleep_q && !wake;

    // Step the mode: stop entry at instruction end, wake on enabled interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_RUN;
            sleep_q <= 1'b0;
        end else begin
            unique case (mode_q)
                MODE_RUN: begin
                    if (last && (halt_cmd || sleep_cmd)) begin
                        mode_q  <= MODE_PUSH;
                        sleep_q <= sleep_cmd;
                    end
                end
                MODE_PUSH: mode_q <= MODE_STOP;
                MODE_STOP: begin
                    if (wake) begin
                        mode_q <= MODE_RUN;
                    end
                end
                default: mode_q <= MODE_RUN;
            endcase
        end
    end

    assert_push_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> !push_req);

    assert_push_follows_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last && (halt_cmd || sleep_cmd)) |=> push_req);

    assert_halt_clock_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP && !sleep_q) |-> !clk_stop);

    assert_stay_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP && !wake) |=> (mode_q == MODE_STOP));

    assert_wake_resumes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP && wake) |=> run_en);

    assert_gate_only_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |-> !run_en);
endmodule

// File: rtl/instr_step_seq.sv
// Top of the instruction step sequencer: length decode, step counter and
// halt/sleep control. Assumes a single clock domain with synchronous reset.
module instr_step_seq #(
    parameter int FETCH_LEN = 3,
    parameter int LEN_SHORT = 5,
    parameter int LEN_MID   = 7,
    parameter int LEN_LONG  = 12,
    parameter int CNT_W     = $clog2(LEN_LONG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       len_class,
    input  logic             halt_cmd,
    input  logic             sleep_cmd,
    input  logic             irq_req,
    input  logic             irq_en,
    output logic [CNT_W-1:0] state_num,
    output logic             exec_phase,
    output logic             instr_end,
    output logic             push_req,
    output logic             clk_stop
);
    logic [CNT_W-1:0] len_clocks;
    logic             run_en;
    logic             last;

    seq_len_decode #(
        .CNT_W(CNT_W), .LEN_SHORT(LEN_SHORT), .LEN_MID(LEN_MID), .LEN_LONG(LEN_LONG)
    ) u_decode (
        .len_class (len_class),
        .len_clocks(len_clocks)
    );

    seq_step_counter #(
        .CNT_W(CNT_W), .FETCH_LEN(FETCH_LEN), .MAX_LEN(LEN_LONG)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .new_len   (len_clocks),
        .last      (last),
        .state_num (state_num),
        .exec_phase(exec_phase)
    );

    seq_stop_ctrl u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .last     (last),
        .halt_cmd (halt_cmd),
        .sleep_cmd(sleep_cmd),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .run_en   (run_en),
        .push_req (push_req),
        .clk_stop (clk_stop)
    );

    assign instr_end = last;

    assert_end_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_end |-> !push_req && !clk_stop);
endmodule

// File: tb/instr_step_seq_tb.sv
module instr_step_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] len_class;
    logic       halt_cmd, sleep_cmd, irq_req, irq_en;
    logic [3:0] state_num;
    logic       exec_phase, instr_end, push_req, clk_stop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state: 0 run, 1 push, 2 stop
    int m_cnt, m_len, m_mode;
    bit m_sleep;
    // observed outputs of the last compared cycle
    int o_state;
    bit o_exec, o_end, o_push, o_stop;

    always #5 clk = ~clk;

    instr_step_seq u_dut (
        .clk(clk), .rst_n(rst_n), .len_class(len_class),
        .halt_cmd(halt_cmd), .sleep_cmd(sleep_cmd),
        .irq_req(irq_req), .irq_en(irq_en),
        .state_num(state_num), .exec_phase(exec_phase),
        .instr_end(instr_end), .push_req(push_req), .clk_stop(clk_stop)
    );

    function automatic int len_of(input logic [1:0] c);
        if (c == 2'b00) return 5;
        if (c == 2'b01) return 7;
        return 12;
    endfunction

    function automatic int cur_len();
        return (m_cnt == 0) ? len_of(len_class) : m_len;
    endfunction

    function automatic bit exp_last();
        return (m_mode == 0) && (m_cnt == cur_len() - 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare outputs against the model, then advance one clock
    task automatic cycle();
        int e_state;
        bit e_exec;
        #1;
        e_exec  = (m_mode == 0) && (m_cnt >= 3);
        e_state = (m_mode != 0) ? 0 : (e_exec ? m_cnt - 3 : m_cnt);
        o_state = int'(state_num);
        o_exec  = exec_phase;
        o_end   = instr_end;
        o_push  = push_req;
        o_stop  = clk_stop;
        chk("R3 state_num", o_state, e_state);
        chk("R2 exec_phase", int'(o_exec), int'(e_exec));
        chk("R5 instr_end", int'(o_end), int'(exp_last()));
        chk("R6 push_req", int'(o_push), int'(m_mode == 1));
        chk("R8 clk_stop", int'(o_stop),
            int'(m_mode == 2 && m_sleep && !(irq_req && irq_en)));
        @(posedge clk);
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_len = 12; m_sleep = 1'b0;
        end else begin
            case (m_mode)
                0: begin
                    bit lst;
                    lst = exp_last();
                    if (m_cnt == 0) m_len = len_of(len_class);
                    if (lst) begin
                        m_cnt = 0;
                        if (halt_cmd || sleep_cmd) begin
                            m_mode = 1; m_sleep = sleep_cmd;
                        end
                    end else begin
                        m_cnt++;
                    end
                end
                1: m_mode = 2;
                default: if (irq_req && irq_en) m_mode = 0;
            endcase
        end
        @(negedge clk);
    endtask

    // run one instruction from step 0, class first in step 0 then cls_rest
    task automatic run_instr(input logic [1:0] cls_first, input logic [1:0] cls_rest,
                             output int n);
        n = 0;
        do begin
            len_class = (m_mode == 0 && m_cnt == 0) ? cls_first : cls_rest;
            cycle();
            n++;
        end while (!o_end && n < 20);
    endtask

    initial begin
        int n;
        void'($urandom(32'd24680));
        rst_n = 1'b0; len_class = 2'b00;
        halt_cmd = 1'b0; sleep_cmd = 1'b0; irq_req = 1'b0; irq_en = 1'b0;
        m_mode = 0; m_cnt = 0; m_len = 12; m_sleep = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R11: outputs at reset
        cycle(); cycle();
        chk("R11 state_num", o_state, 0);
        chk("R11 outputs", int'({o_exec, o_end, o_push, o_stop}), 0);
        rst_n = 1'b1;

        // R1: each class
        for (int c = 0; c < 4; c++) begin
            run_instr(2'(c), 2'(c), n);
            chk("R1 length", n, len_of(2'(c)));
        end
        // R4: class changed after step 0
        run_instr(2'b00, 2'b10, n);
        chk("R4 short kept", n, 5);
        run_instr(2'b10, 2'b00, n);
        chk("R4 long kept", n, 12);

        // R7 / R9: halt with interrupts disabled
        halt_cmd = 1'b1;
        run_instr(2'b01, 2'b01, n);
        chk("R12 halt mid-instr ignored", n, 7);
        halt_cmd = 1'b0;
        cycle();
        chk("R6 push after halt", int'(o_push), 1);
        irq_req = 1'b1; irq_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            cycle();
            chk("R7 halt clock runs", int'(o_stop), 0);
            chk("R9 still stopped", int'(o_end || o_exec || o_push), 0);
        end
        irq_en = 1'b1;
        cycle();
        chk("R10 wake seen", int'(o_stop), 0);
        irq_req = 1'b0;
        run_instr(2'b01, 2'b01, n);
        chk("R10 full instr after wake", n, 7);

        // R8: sleep and halt together, sleep wins
        halt_cmd = 1'b1; sleep_cmd = 1'b1;
        run_instr(2'b00, 2'b00, n);
        halt_cmd = 1'b0; sleep_cmd = 1'b0;
        cycle();
        chk("R6 push after sleep", int'(o_push), 1);
        irq_req = 1'b1; irq_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            cycle();
            chk("R8 sleep gates clock", int'(o_stop), 1);
        end
        irq_en = 1'b1;
        cycle();
        chk("R10 clk_stop released same cycle", int'(o_stop), 0);
        irq_req = 1'b0;
        run_instr(2'b10, 2'b10, n);
        chk("R10 resumes at fetch 0", n, 12);

        // R12: halt only in early steps has no effect
        len_class = 2'b00; halt_cmd = 1'b1;
        cycle(); cycle();
        halt_cmd = 1'b0;
        run_instr(2'b00, 2'b00, n);
        chk("R12 remaining steps", n, 3);
        cycle();
        chk("R12 no push", int'(o_push), 0);
        cycle();
        chk("R12 still running", o_state, 1);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            len_class = 2'($urandom % 4);
            halt_cmd  = ($urandom % 8) == 0;
            sleep_cmd = ($urandom % 12) == 0;
            irq_req   = ($urandom % 6) == 0;
            irq_en    = ($urandom % 2) == 1;
            cycle();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule